// File: doc/BRIEF.md
# Inbound Window Base Register Bank

This block holds the base addresses of three inbound windows through which a PCI host reaches local memory. Each window is visible from two sides. The configuration side sees it as a base address register in PCI configuration space. The local CSR side sees an internal base register and an attribute register. The attribute register sets the window size and the prefetch flag. Both sides share one stored base per window, so a write from either side shows on both read paths at the next read.

The window size sets how many low base bits take part. Base bits inside the window span are masked: writes leave them alone and reads return them as zero. The mask is worked out every cycle from the programmed size. A change of size therefore takes effect on the very next access, with no copy or recompute step. Reads on both sides are combinational. Writes take effect at the next rising clock edge.

Top module: `inbound_bar_shadow`

## Requirements
- R1: After reset, every base, prefetch flag and size field reads zero on both sides.
- R2: Configuration offsets 0x10, 0x14 and 0x18 select windows 0, 1 and 2. At any other offset `cfg_hit` is 0, `cfg_rdata` is 0 and a write changes nothing. A CSR index of 3 reads zero and its writes are ignored.
- R3: A configuration read returns the base in bits 31..12 and zero in bits 11..4 and 2..0. Bit 3 carries the prefetch flag, which is attribute bit 29.
- R4: Attribute bits 4..0 hold a size code n. Codes below 11 act as 11. Base bits at positions up to and including n are masked and read zero on both sides, so code 11 keeps bits 31..12 and code 31 masks all of them.
- R5: A write from either side never changes a masked base bit. A bit that was masked shows its old stored value again once a smaller size unmasks it.
- R6: Configuration byte enable k covers data bits 8k+7..8k. Only enabled, unmasked base bits are written.
- R7: A configuration write to a window is seen on `csr_base_rdata` after the next clock edge.
- R8: A CSR base write uses all 32 data bits, applies the same mask, and is seen on the configuration read after the next clock edge.
- R9: When a CSR base write and a configuration write target the same window in the same cycle, only the CSR write takes effect. When they target different windows, both take effect.
- R10: The attribute register stores only bit 29 and bits 4..0. All its other bits read zero. The mask used in a cycle comes from the size held before that cycle's edge.
- R11: Configuration writes cannot change bits 11..0, so the prefetch flag can be set only from the CSR side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Configuration write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| cfg_hit | output | 1 | `cfg_addr` selects a window register |
| csr_sel | input | 2 | Window index for the CSR side |
| csr_base_wr | input | 1 | Write strobe for the internal base register |
| csr_attr_wr | input | 1 | Write strobe for the attribute register |
| csr_wdata | input | 32 | CSR write data |
| csr_base_rdata | output | 32 | Internal base register of the selected window, masked |
| csr_attr_rdata | output | 32 | Attribute register of the selected window |

## Verification
A wrong stored base bit or a wrong mask shows at once on both read ports. They are combinational, so the error is visible in the cycle right after the faulty edge, whenever that window is addressed. A masked bit that was written by mistake stays hidden while its size is held. It appears only when a smaller size code unmasks it, so the bench shrinks windows after writing all-ones under a large size. A lost priority between the two writers shows one cycle after a same-window collision, as the configuration data in place of the CSR data.

// File: rtl/inbound_bar_shadow.sv
module inbound_bar_shadow #(
  parameter int NWIN     = 3,
  parameter int ADDR_W   = 8,
  parameter int BAR0_OFF = 'h10,
  parameter int SZ_W     = 5,
  parameter int MIN_SZ   = 11,
  parameter int PF_BIT   = 29
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic                     cfg_wr,
  input  logic [3:0]               cfg_be,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic                     cfg_hit,
  input  logic [$clog2(NWIN)-1:0]  csr_sel,
  input  logic                     csr_base_wr,
  input  logic                     csr_attr_wr,
  input  logic [31:0]              csr_wdata,
  output logic [31:0]              csr_base_rdata,
  output logic [31:0]              csr_attr_rdata
);
  localparam int SEL_W = $clog2(NWIN);
  localparam int LO    = MIN_SZ + 1;
  localparam int BW    = 32 - LO;

  logic [NWIN-1:0][BW-1:0]   base_q;
  logic [NWIN-1:0][SZ_W-1:0] sz_q;
  logic [NWIN-1:0]           pf_q;
  logic [NWIN-1:0][BW-1:0]   keep;
  logic [NWIN-1:0][BW-1:0]   cfg_m;
  logic [NWIN-1:0]           cfg_w, csr_w;
  logic [BW-1:0]             be_bits;

  always_comb
    for (int b = 0; b < BW; b++) be_bits[b] = cfg_be[(b + LO) / 8];

  wire unused_ok = ^{cfg_wdata[LO-1:0], csr_wdata[LO-1:0]} ^ cfg_be[0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(BAR0_OFF + 4 * w);
    logic [SZ_W-1:0] eff;
    assign eff = (sz_q[w] < SZ_W'(MIN_SZ)) ? SZ_W'(MIN_SZ) : sz_q[w];
    always_comb
      for (int b = 0; b < BW; b++) keep[w][b] = (b + LO) > int'(eff);
    assign cfg_w[w] = cfg_wr && cfg_addr == OFF;
    assign csr_w[w] = csr_sel == SEL_W'(w);
    assign cfg_m[w] = keep[w] & be_bits;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        base_q[w] <= '0;
        sz_q[w]   <= '0;
        pf_q[w]   <= 1'b0;
      end else begin
        if (csr_base_wr && csr_w[w])
          base_q[w] <= (csr_wdata[31:LO] & keep[w]) | (base_q[w] & ~keep[w]);
        else if (cfg_w[w])
          base_q[w] <= (cfg_wdata[31:LO] & cfg_m[w]) | (base_q[w] & ~cfg_m[w]);
        if (csr_attr_wr && csr_w[w]) begin
          sz_q[w] <= csr_wdata[SZ_W-1:0];
          pf_q[w] <= csr_wdata[PF_BIT];
        end
      end

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((base_q[w] & ~$past(keep[w])) == ($past(base_q[w]) & ~$past(keep[w]))));
    // R9
    csr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_base_wr && csr_w[w]) |=>
        ((base_q[w] & $past(keep[w])) == ($past(csr_wdata[31:LO]) & $past(keep[w]))));
    // R6
    cfg_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_w[w] && !(csr_base_wr && csr_w[w])) |=>
        ((base_q[w] & $past(cfg_m[w])) == ($past(cfg_wdata[31:LO]) & $past(cfg_m[w]))));
    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_w[w] || (csr_base_wr && csr_w[w])) |=> $stable(base_q[w]));
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_hit   = 1'b0;
    for (int w = 0; w < NWIN; w++)
      if (cfg_addr == ADDR_W'(BAR0_OFF + 4 * w)) begin
        cfg_hit   = 1'b1;
        cfg_rdata = {base_q[w] & keep[w], {(LO-4){1'b0}}, pf_q[w], 3'b000};
      end
  end

  always_comb begin
    csr_base_rdata = '0;
    csr_attr_rdata = '0;
    for (int w = 0; w < NWIN; w++)
      if (csr_w[w]) begin
        csr_base_rdata = {base_q[w] & keep[w], {LO{1'b0}}};
        csr_attr_rdata[PF_BIT]     = pf_q[w];
        csr_attr_rdata[SZ_W-1:0]   = sz_q[w];
      end
  end
endmodule

// File: tb/tb_inbound_bar_shadow.sv
module tb_inbound_bar_shadow;
  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_addr = 0;
  logic cfg_wr = 0, csr_base_wr = 0, csr_attr_wr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, csr_wdata = 0;
  logic [1:0] csr_sel = 0;
  logic [31:0] cfg_rdata, csr_base_rdata, csr_attr_rdata;
  logic cfg_hit;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_base [3];
  logic [4:0]  m_sz [3];
  logic        m_pf [3];

  always #5 clk = ~clk;

  inbound_bar_shadow dut (.*);

  function automatic logic [31:0] kmask(logic [4:0] n);
    int e = (n < 11) ? 11 : int'(n);
    logic [31:0] m = 0;
    for (int i = 12; i < 32; i++) if (i > e) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    int ci;
    #2;
    ci = (cfg_addr == 8'h10) ? 0 : (cfg_addr == 8'h14) ? 1 : (cfg_addr == 8'h18) ? 2 : -1;
    if (ci >= 0) begin
      chk({tag, " cfg_hit"}, 32'(cfg_hit), 1);
      chk({tag, " cfg_rdata"}, cfg_rdata,
          (m_base[ci] & kmask(m_sz[ci])) | (32'(m_pf[ci]) << 3));
    end else begin
      chk({tag, " cfg_hit"}, 32'(cfg_hit), 0);
      chk({tag, " cfg_rdata"}, cfg_rdata, 0);
    end
    if (csr_sel < 3) begin
      chk({tag, " csr_base"}, csr_base_rdata, m_base[csr_sel] & kmask(m_sz[csr_sel]));
      chk({tag, " csr_attr"}, csr_attr_rdata,
          (32'(m_pf[csr_sel]) << 29) | 32'(m_sz[csr_sel]));
    end else begin
      chk({tag, " csr_base"}, csr_base_rdata, 0);
      chk({tag, " csr_attr"}, csr_attr_rdata, 0);
    end
    @(posedge clk);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] km = kmask(m_sz[w]);
      logic [31:0] bm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}} & km;
      if (csr_base_wr && csr_sel == w)
        m_base[w] = (csr_wdata & km) | (m_base[w] & ~km);
      else if (cfg_wr && cfg_addr == 8'(16 + 4 * w))
        m_base[w] = (cfg_wdata & bm) | (m_base[w] & ~bm);
      if (csr_attr_wr && csr_sel == w) begin
        m_sz[w] = csr_wdata[4:0];
        m_pf[w] = csr_wdata[29];
      end
    end
    @(negedge clk);
    cfg_wr = 0; csr_base_wr = 0; csr_attr_wr = 0;
  endtask

  task automatic probe(string tag);
    for (int w = 0; w < 3; w++) begin
      cfg_addr = 8'(16 + 4 * w); csr_sel = 2'(w);
      tick(tag);
    end
  endtask

  task automatic cfgw(int w, logic [3:0] be, logic [31:0] d, string tag);
    cfg_addr = 8'(16 + 4 * w); cfg_be = be; cfg_wdata = d; cfg_wr = 1;
    tick(tag);
  endtask

  task automatic csrw(int w, bit attr, logic [31:0] d, string tag);
    csr_sel = 2'(w); csr_wdata = d;
    if (attr) csr_attr_wr = 1; else csr_base_wr = 1;
    tick(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin m_base[w] = 0; m_sz[w] = 0; m_pf[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    probe("R1 reset");
    cfgw(0, 4'hF, 32'hFFFF_FFFF, "R7 cfg write");
    probe("R7 readback");
    csrw(1, 1, 32'h2000_000B, "R3 pf set");
    probe("R3 read format");
    csrw(1, 1, 32'hFFFF_FFFF, "R10 attr all ones");
    probe("R10 attr bits");
    csrw(2, 1, 32'h0000_000F, "R4 size 15");
    cfgw(2, 4'hF, 32'hFFFF_FFFF, "R4 write under size 15");
    probe("R4 masked read");
    csrw(2, 1, 32'h0000_0003, "R5 shrink");
    probe("R5 masked bits kept");
    cfgw(2, 4'b0100, 32'h0000_0000, "R6 single byte");
    probe("R6 byte enable");
    cfgw(1, 4'hF, 32'h1234_5FFF, "R11 low bits");
    probe("R11 pf untouched");
    csrw(0, 0, 32'hA5A5_AFFF, "R8 csr base");
    probe("R8 readback");
    cfg_addr = 8'h1C; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF; cfg_wr = 1;
    tick("R2 stray offset");
    csrw(3, 0, 32'hFFFF_FFFF, "R2 bad index");
    probe("R2 no effect");
    cfg_addr = 8'h10; cfg_be = 4'hF; cfg_wdata = 32'h1111_1000; cfg_wr = 1;
    csr_sel = 0; csr_wdata = 32'h2222_2000; csr_base_wr = 1;
    tick("R9 same window");
    probe("R9 csr wins");
    cfg_addr = 8'h14; cfg_be = 4'hF; cfg_wdata = 32'h3333_3000; cfg_wr = 1;
    csr_sel = 2; csr_wdata = 32'h4444_4000; csr_base_wr = 1;
    tick("R9 split windows");
    probe("R9 both taken");
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      cfg_addr = 8'(16 + 4 * $urandom_range(0, 3));
      csr_sel = 2'($urandom_range(0, 3));
      cfg_be = 4'($urandom); cfg_wdata = $urandom; csr_wdata = $urandom;
      if (r < 2) csr_wdata[4:0] = 5'($urandom_range(9, 20));
      cfg_wr = r > 4; csr_base_wr = r == 2 || r == 9; csr_attr_wr = r < 2;
      tick("R4 R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule